// File: doc/BRIEF.md
# Nonvolatile Byte Memory Write-Access Controller

This block sits between a CPU register bus and a byte-wide nonvolatile data memory. Software sees three registers: an address register, a data register and a control register. It selects one with a two-bit select, writes it with a one-cycle strobe, and reads the selected register back at any time. The control register holds three bits: an arm bit, a write-enable bit and a read-enable bit. A read copies the addressed byte into the data register and stalls the CPU for a short time.

A write is guarded. Software first sets the arm bit, which the hardware clears on its own after a short window. The write starts only if write-enable is set while the arm bit is still up, no write is already running, and the flash self-programming busy input is low. The write then runs for a long counted period set by a parameter. During that period the write-enable bit reads as one, reads and address changes are refused, and the byte reaches the memory when the period ends, together with a one-cycle done pulse. The storage is a plain behavioural byte array. The reset input is asynchronous and active-low, and it is released synchronously inside the block.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After reset, every register reads zero: address, data and control. `nvm_busy`, `cpu_stall` and `wr_done` are low.
- R2: Writing the control register (select 2) with bit 2 set, while no write is running, sets the arm bit. The arm bit reads as one for the ARM_WINDOW (4) cycles after that bus write. The hardware then clears it.
- R3: A write starts only when a control write has bit 1 set and the arm bit was already set before that bus write. A write that starts clears the arm bit. A control write that sets bits 2 and 1 together when the arm bit is clear only arms. In every case without a start, bit 1 stays zero and the memory is not changed.
- R4: After a start, `nvm_busy` and control bit 1 stay high for exactly WR_CYCLES cycles. In the cycle they fall, `wr_done` is high for one cycle. From then on the memory holds, at the address latched at the start, the data register value latched at the start.
- R5: A write start raises `cpu_stall` for exactly 2 cycles, beginning in the cycle after the bus write.
- R6: When idle, a control write with bit 0 set loads the data register with the byte at the current address in the next cycle. Control bit 0 reads one for that cycle and zero after it. `cpu_stall` is high for exactly 4 cycles.
- R7: While `nvm_busy` is high, the block ignores writes to the address register and all control writes. This covers the read, arm and write-enable bits: the data register, the stall output and the control bits are unchanged.
- R8: When `flash_busy` is high in the cycle of the write-enable bus write, no write starts.
- R9: The read-back mux gives the following. Select 0 gives the address, zero-extended. Select 1 gives the data register, which software can write at any time. Select 2 gives {zeros, arm, write-enable, read-enable} in bits 2..0. Select 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 none |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read-back of the selected register |
| flash_busy | input | 1 | Flash self-programming in progress, blocks write start |
| cpu_stall | output | 1 | CPU stall request |
| nvm_busy | output | 1 | Write in progress |
| wr_done | output | 1 | One-cycle pulse when a write completes |

## Verification
Two situations are hard to reach from the ports.

The first is the edge of the arm window. A write-enable that arrives exactly on the last armed cycle must start a write, and one that arrives a single cycle later must be refused. The stimulus inserts a random gap of 0 to 5 idle cycles between arming and write-enable, so both sides of that boundary are covered many times.

The second is a collision at the start cycle and with a write in flight. The bench raises `flash_busy` for the write-enable cycle only. It also pokes address, read and arm requests into a running write, and then checks that nothing moved and that the memory kept its old byte.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_RE_BIT  = 0;
  localparam int CTRL_WE_BIT  = 1;
  localparam int CTRL_ARM_BIT = 2;

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WINDOW + 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  assign upd_en = consume | arm_req | armed_q;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (consume) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (arm_req) begin
      armed_d = 1'b1;
      cnt_d   = CW'(WINDOW - 1);
    end else if (armed_q) begin
      if (cnt_q == '0) armed_d = 1'b0;
      else             cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
  parameter int WR_CYCLES = 8448,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              done
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic              busy_q, busy_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;
  logic              run_en;

  assign commit = busy_q && (cnt_q == '0);
  assign run_en = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (run_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      addr_q <= start_addr;
      data_q <= start_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= commit;
  end

  assign busy        = busy_q;
  assign commit_addr = addr_q;
  assign commit_data = data_q;
  assign done        = done_q;
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int WR_STALL = 2,
  parameter int RD_STALL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_wr,
  input  logic load_rd,
  output logic stall
);
  localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
  localparam int CW   = $clog2(MAXS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_wr | load_rd | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr)             cnt_d = CW'(WR_STALL);
    else if (load_rd)        cnt_d = CW'(RD_STALL);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign stall = (cnt_q != '0);
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_wr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 8448,
  parameter int ARM_WINDOW = 4,
  parameter int WR_STALL   = 2,
  parameter int RD_STALL   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flash_busy,
  output logic              cpu_stall,
  output logic              nvm_busy,
  output logic              wr_done
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  reg_sel_e          sel;
  logic              ctrl_wr, wr_start, rd_go, arm_req, armed, busy;
  logic              addr_en, data_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              re_q;
  logic [DATA_W-1:0] mem_rdata, commit_data, ctrl_view;
  logic [ADDR_W-1:0] commit_addr;
  logic              commit;

  assign sel      = reg_sel_e'(bus_sel);
  assign ctrl_wr  = bus_wr && (sel == SEL_CTRL) && !busy;
  assign wr_start = ctrl_wr && bus_wdata[CTRL_WE_BIT] && armed && !flash_busy;
  assign rd_go    = ctrl_wr && bus_wdata[CTRL_RE_BIT] && !wr_start;
  assign arm_req  = ctrl_wr && bus_wdata[CTRL_ARM_BIT];

  // next-state for the software-visible registers
  always_comb begin
    addr_en = bus_wr && (sel == SEL_ADDR) && !busy;
    addr_d  = bus_wdata[ADDR_W-1:0];
    data_en = rd_go || (bus_wr && (sel == SEL_DATA));
    data_d  = rd_go ? mem_rdata : bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) re_q <= 1'b0;
    else          re_q <= rd_go;
  end

  nvm_arm_window #(.WINDOW(ARM_WINDOW)) arm_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .arm_req (arm_req),
    .consume (wr_start),
    .armed   (armed)
  );

  nvm_write_timer #(.WR_CYCLES(WR_CYCLES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) timer_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (wr_start),
    .start_addr  (addr_q),
    .start_data  (data_q),
    .busy        (busy),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .done        (wr_done)
  );

  nvm_stall_gen #(.WR_STALL(WR_STALL), .RD_STALL(RD_STALL)) stall_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_wr (wr_start),
    .load_rd (rd_go),
    .stall   (cpu_stall)
  );

  nvm_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .rd_addr (addr_q),
    .rd_data (mem_rdata)
  );

  always_comb begin
    ctrl_view               = '0;
    ctrl_view[CTRL_ARM_BIT] = armed;
    ctrl_view[CTRL_WE_BIT]  = busy;
    ctrl_view[CTRL_RE_BIT]  = re_q;
    unique case (sel)
      SEL_ADDR: bus_rdata = DATA_W'(addr_q);
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = ctrl_view;
      default:  bus_rdata = '0;
    endcase
  end

  assign nvm_busy = busy;
endmodule

// File: rtl/nvm_wr_ctrl_chk.sv
module nvm_wr_ctrl_chk #(
  parameter int WR_CYCLES  = 8448,
  parameter int ARM_WINDOW = 4,
  parameter int ADDR_W     = 6
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              arm_req,
  input logic              armed,
  input logic              flash_busy,
  input logic              nvm_busy,
  input logic              cpu_stall,
  input logic              wr_done,
  input logic [ADDR_W-1:0] addr_q,
  input logic              re_q
);
  logic [7:0] arm_age_q;
  int         busy_len_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)              arm_age_q <= '0;
    else if (arm_req)          arm_age_q <= '0;
    else if (armed && arm_age_q != 8'hFF) arm_age_q <= arm_age_q + 1'b1;
    else if (!armed)           arm_age_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      busy_len_q <= 0;
    else if (nvm_busy) busy_len_q <= busy_len_q + 1;
    else               busy_len_q <= 0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_s |-> (!nvm_busy && !cpu_stall && !wr_done && !armed && !re_q));

  assert_arm_window_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    armed |-> (int'(arm_age_q) < ARM_WINDOW));

  assert_start_armed_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(nvm_busy) |-> $past(armed));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(nvm_busy) |-> (busy_len_q == WR_CYCLES));

  assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_done |-> $fell(nvm_busy));

  assert_stall_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(nvm_busy) |-> cpu_stall);

  assert_read_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    re_q |-> cpu_stall);

  assert_addr_locked_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (nvm_busy && $past(nvm_busy)) |-> $stable(addr_q));

  assert_no_read_busy_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    re_q |-> !$past(nvm_busy));

  assert_flash_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(nvm_busy) |-> !$past(flash_busy));
endmodule

bind nvm_wr_ctrl nvm_wr_ctrl_chk #(
  .WR_CYCLES  (WR_CYCLES),
  .ARM_WINDOW (ARM_WINDOW),
  .ADDR_W     (ADDR_W)
) chk_i (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .arm_req    (arm_req),
  .armed      (armed),
  .flash_busy (flash_busy),
  .nvm_busy   (nvm_busy),
  .cpu_stall  (cpu_stall),
  .wr_done    (wr_done),
  .addr_q     (addr_q),
  .re_q       (re_q)
);

// File: tb/nvm_wr_ctrl_tb_top.sv
module nvm_wr_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int WC = 24;
  localparam int AWIN = 4;
  localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_NONE = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_sel = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic          flash_busy = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          cpu_stall, nvm_busy, wr_done;

  int unsigned cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_mem [1 << AW];
  bit known [1 << AW];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_wr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WR_CYCLES(WC), .ARM_WINDOW(AWIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flash_busy(flash_busy), .cpu_stall(cpu_stall),
    .nvm_busy(nvm_busy), .wr_done(wr_done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [DW-1:0] v);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [DW-1:0] v);
    bus_sel = s;
    #1;
    v = bus_rdata;
  endtask

  function automatic bit expect_start(input int gap, input bit fb);
    return (gap < AWIN) && !fb;
  endfunction

  task automatic do_read(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    bus_write(S_ADDR, DW'(a));
    bus_write(S_CTRL, 8'h01);
    peek(S_CTRL, v);
    chk("R6", "read strobe visible", 32'(v[0]), 1);
    chk("R6", "read stall begins", 32'(cpu_stall), 1);
    if (known[a]) begin
      peek(S_DATA, v);
      chk("R6", "read data", 32'(v), 32'(exp_mem[a]));
    end
    idle(1);
    peek(S_CTRL, v);
    chk("R6", "read strobe self-clears", 32'(v[0]), 0);
    idle(2);
    chk("R6", "stall held 4th cycle", 32'(cpu_stall), 1);
    idle(1);
    chk("R6", "stall ends after 4", 32'(cpu_stall), 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int gap, input bit fb, input bit poke);
    logic [DW-1:0] v;
    int unsigned t0;
    bit go;
    bus_write(S_ADDR, DW'(a));
    bus_write(S_DATA, d);
    bus_write(S_CTRL, 8'h04);
    peek(S_CTRL, v);
    chk("R2", "arm bit set", 32'(v[2]), 1);
    idle(gap);
    flash_busy = fb;
    bus_write(S_CTRL, 8'h02);
    flash_busy = 1'b0;
    go = expect_start(gap, fb);
    peek(S_CTRL, v);
    chk(fb ? "R8" : "R3", "write-enable bit", 32'(v[1]), 32'(go));
    chk("R3", "busy after request", 32'(nvm_busy), 32'(go));
    if (go) begin
      t0 = cyc;
      chk("R3", "arm consumed", 32'(v[2]), 0);
      chk("R5", "stall cycle 1", 32'(cpu_stall), 1);
      idle(1);
      chk("R5", "stall cycle 2", 32'(cpu_stall), 1);
      idle(1);
      chk("R5", "stall over", 32'(cpu_stall), 0);
      if (poke) begin
        bus_write(S_ADDR, DW'(a ^ 6'h01));
        peek(S_ADDR, v);
        chk("R7", "address locked", 32'(v), 32'(a));
        bus_write(S_CTRL, 8'h05);
        peek(S_CTRL, v);
        chk("R7", "control ignored", 32'(v), 32'h02);
        chk("R7", "no read stall", 32'(cpu_stall), 0);
        peek(S_DATA, v);
        chk("R7", "data unchanged", 32'(v), 32'(d));
      end
      while (nvm_busy) @(negedge clk);
      chk("R4", "busy length", cyc - t0, WC);
      chk("R4", "done pulse", 32'(wr_done), 1);
      idle(1);
      chk("R4", "done one cycle", 32'(wr_done), 0);
      exp_mem[a] = d;
      known[a] = 1'b1;
    end else begin
      chk("R5", "no stall without start", 32'(cpu_stall), 0);
      idle(AWIN);
    end
    do_read(a);
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h5eed));
    idle(2);
    rst_n = 1'b1;
    idle(4);
    peek(S_CTRL, v); chk("R1", "control after reset", 32'(v), 0);
    peek(S_ADDR, v); chk("R1", "address after reset", 32'(v), 0);
    peek(S_DATA, v); chk("R1", "data after reset", 32'(v), 0);
    chk("R1", "busy/stall/done after reset", {29'd0, nvm_busy, cpu_stall, wr_done}, 0);

    // R9: mux and zero extension
    bus_write(S_ADDR, 8'hFF);
    peek(S_ADDR, v); chk("R9", "address zero-extended", 32'(v), 32'h3F);
    bus_write(S_DATA, 8'hA5);
    peek(S_DATA, v); chk("R9", "data read-back", 32'(v), 32'hA5);
    peek(S_NONE, v); chk("R9", "select 3 reads zero", 32'(v), 0);

    // R2: exact window length
    bus_write(S_CTRL, 8'h04);
    idle(AWIN - 1);
    peek(S_CTRL, v); chk("R2", "armed on last window cycle", 32'(v[2]), 1);
    idle(1);
    peek(S_CTRL, v); chk("R2", "arm cleared after window", 32'(v[2]), 0);

    // R3: arm and write-enable together from unarmed only arms
    bus_write(S_CTRL, 8'h06);
    peek(S_CTRL, v);
    chk("R3", "combined write arms only", 32'(v), 32'h04);
    chk("R3", "combined write no busy", 32'(nvm_busy), 0);
    idle(AWIN);

    // directed corner writes
    do_write(6'd10, 8'h3C, 0, 1'b0, 1'b1);
    do_write(6'd11, 8'hC3, AWIN - 1, 1'b0, 1'b0);
    do_write(6'd10, 8'h99, AWIN, 1'b0, 1'b0);
    do_write(6'd11, 8'h55, 1, 1'b1, 1'b0);

    for (int i = 0; i < 40; i++) begin
      int unsigned r;
      logic [AW-1:0] a;
      r = $urandom % 4;
      a = AW'($urandom % 16);
      if (r < 2)
        do_write(a, DW'($urandom), int'($urandom % 6), ($urandom % 5) == 0, ($urandom % 3) == 0);
      else
        do_read(a);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule